// File: doc/BRIEF.md
# Pointer Justification Event Counters

This block accumulates the positive and negative pointer justification events that an upstream pointer interpreter reports. It keeps one running count for each direction. Each count is 11 bits wide by default. At every performance monitoring boundary, marked by a one-cycle strobe from an external interval timer, the running counts are transferred into a pair of holding registers. The running counts then restart for the next interval. Host access logic reads the holding registers directly.

A configuration input chooses how a running count behaves at the top of its range. It either wraps back to zero or sticks at its maximum. Three alarm inputs force every count to zero for as long as any of them is high: loss of pointer, path AIS, and an auto-AIS request from elsewhere in the chip. The same alarms also discard any events that arrive during that time. This prevents a failed path from reporting meaningless justification activity.

Top module: `ptr_pm_top`

## Requirements
- R1: Increment pulses (`inc_i`) and decrement pulses (`dec_i`) are counted in two independent running counts. When both are high in one cycle, each count advances by one.
- R2: When `interval_end_i` is high and no alarm is active, each running count (excluding that cycle's pulse) appears on its latched output after the next rising clock edge.
- R3: On the same strobe, the running counts restart. A pulse that coincides with the strobe is counted into the new interval, so that count becomes 1.
- R4: With `sat_en_i` = 0, a running count at 2047 that receives one more pulse becomes 0.
- R5: With `sat_en_i` = 1, a running count at 2047 stays at 2047 on further pulses.
- R6: One rising edge after `lop_i`, `ais_i` or `auto_ais_i` goes high, both running counts and both latched outputs are zero. They stay zero while the alarm is high.
- R7: Pulses that arrive while `lop_i` is high are not counted, including after the alarm clears.
- R8: After reset, both latched outputs and both running counts are zero.
- R9: Without a strobe and without an alarm, the latched outputs do not change, whatever pulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Pointer increment event pulse |
| dec_i | input | 1 | Pointer decrement event pulse |
| interval_end_i | input | 1 | One-cycle end of monitoring interval strobe |
| lop_i | input | 1 | Loss of pointer alarm |
| ais_i | input | 1 | Path AIS alarm |
| auto_ais_i | input | 1 | External auto-AIS request |
| sat_en_i | input | 1 | 1 = saturate at maximum, 0 = wrap |
| inc_latched_o | output | 11 | Increment count of the last finished interval |
| dec_latched_o | output | 11 | Decrement count of the last finished interval |

## Verification
Two cases can fall in the same cycle. First, an event pulse can arrive together with the interval strobe. The bench provokes this by raising `inc_i` during the strobe cycle. It judges the result at the boundary that follows: the latched value must be one more than the pulses given inside the new interval. Second, an alarm can arrive together with the strobe or with pulses. Here the bench expects zero on the outputs at the next edge, and zero again at the strobe after the alarm clears.

// File: rtl/ptr_pm_pkg.sv
package ptr_pm_pkg;

  typedef enum logic {
    CNT_WRAP = 1'b0,
    CNT_SAT  = 1'b1
  } cnt_mode_e;

  typedef struct packed {
    logic clear;   // alarm: zero everything
    logic strobe;  // interval boundary, alarm-free
  } pm_ctrl_t;

endpackage

// File: rtl/ptr_pm_ctrl.sv
module ptr_pm_ctrl
  import ptr_pm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      interval_end_i,
  input  logic      lop_i,
  input  logic      ais_i,
  input  logic      auto_ais_i,
  output pm_ctrl_t  ctrl_o
);

  logic alarm;

  always_comb begin
    alarm         = lop_i | ais_i | auto_ais_i;
    ctrl_o.clear  = alarm;
    ctrl_o.strobe = interval_end_i & ~alarm;
  end

  assert_ctrl_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_o.clear && ctrl_o.strobe));

  assert_lop_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lop_i |-> ctrl_o.clear);

endmodule

// File: rtl/ptr_pm_counter.sv
module ptr_pm_counter
  import ptr_pm_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pm_ctrl_t         ctrl_i,
  input  cnt_mode_e        mode_i,
  input  logic             evt_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_max;

  always_comb begin
    at_max = (cnt_q == CNT_MAX);
    cnt_d  = cnt_q;
    if (ctrl_i.clear) begin
      cnt_d = '0;
    end else if (ctrl_i.strobe) begin
      cnt_d = evt_i ? CNT_ONE : '0;
    end else if (evt_i) begin
      if (mode_i == CNT_SAT && at_max) cnt_d = CNT_MAX;
      else                              cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_cnt_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.clear |=> (cnt_o == '0));

  assert_cnt_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.strobe |=> (cnt_o == CNT_W'($past(evt_i))));

  assert_cnt_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.clear && !ctrl_i.strobe && mode_i == CNT_SAT && cnt_o == CNT_MAX)
    |=> (cnt_o == CNT_MAX));

  assert_cnt_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.clear && !ctrl_i.strobe && evt_i && mode_i == CNT_WRAP && cnt_o == CNT_MAX)
    |=> (cnt_o == '0));

  assert_cnt_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.clear && !ctrl_i.strobe && !evt_i) |=> $stable(cnt_o));

endmodule

// File: rtl/ptr_pm_latch.sv
module ptr_pm_latch
  import ptr_pm_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pm_ctrl_t         ctrl_i,
  input  logic [CNT_W-1:0] run_i,
  output logic [CNT_W-1:0] held_o
);

  logic [CNT_W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            held_q <= '0;
    else if (ctrl_i.clear)  held_q <= '0;
    else if (ctrl_i.strobe) held_q <= run_i;
  end

  assign held_o = held_q;

  assert_latch_copy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.strobe |=> (held_o == $past(run_i)));

  assert_latch_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.clear && !ctrl_i.strobe) |=> $stable(held_o));

  assert_latch_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.clear |=> (held_o == '0));

endmodule

// File: rtl/ptr_pm_top.sv
module ptr_pm_top
  import ptr_pm_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             interval_end_i,
  input  logic             lop_i,
  input  logic             ais_i,
  input  logic             auto_ais_i,
  input  logic             sat_en_i,
  output logic [CNT_W-1:0] inc_latched_o,
  output logic [CNT_W-1:0] dec_latched_o
);

  localparam int N_CH = 2;  // 0: increment, 1: decrement

  pm_ctrl_t         ctrl;
  cnt_mode_e        mode;
  logic [N_CH-1:0]  evt;
  logic [CNT_W-1:0] run  [N_CH];
  logic [CNT_W-1:0] held [N_CH];

  assign mode = cnt_mode_e'(sat_en_i);
  assign evt  = {dec_i, inc_i};

  ptr_pm_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .interval_end_i (interval_end_i),
    .lop_i          (lop_i),
    .ais_i          (ais_i),
    .auto_ais_i     (auto_ais_i),
    .ctrl_o         (ctrl)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    ptr_pm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctrl_i (ctrl),
      .mode_i (mode),
      .evt_i  (evt[g]),
      .cnt_o  (run[g])
    );

    ptr_pm_latch #(.CNT_W(CNT_W)) u_lat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctrl_i (ctrl),
      .run_i  (run[g]),
      .held_o (held[g])
    );
  end

  assign inc_latched_o = held[0];
  assign dec_latched_o = held[1];

  assert_out_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lop_i || ais_i || auto_ais_i) |=> (inc_latched_o == '0 && dec_latched_o == '0));

endmodule

// File: tb/sim_ptr_pm_top.sv
module sim_ptr_pm_top;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 11;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic inc = 0, dec = 0, iend = 0, lop = 0, ais = 0, aais = 0, sat = 0;
  logic [W-1:0] inc_l, dec_l;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_pm_top #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .inc_i(inc), .dec_i(dec),
    .interval_end_i(iend), .lop_i(lop), .ais_i(ais), .auto_ais_i(aais),
    .sat_en_i(sat), .inc_latched_o(inc_l), .dec_latched_o(dec_l)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(int ni, int nd);
    int n = (ni > nd) ? ni : nd;
    for (int k = 0; k < n; k++) begin
      inc = (k < ni);
      dec = (k < nd);
      step();
    end
    inc = 0; dec = 0;
  endtask

  task automatic boundary();
    iend = 1;
    step();
    iend = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R8 inc in reset", inc_l, 0);
    chk("R8 dec in reset", dec_l, 0);
    rst_n = 1;
    step();
    boundary();
    chk("R8 inc after reset", inc_l, 0);
    chk("R8 dec after reset", dec_l, 0);

    // R1/R2: near-exhaustive sweep of small counts, incl. simultaneous pulses
    for (int a = 0; a <= 12; a++) begin
      for (int b = 0; b <= 12; b++) begin
        pulse(a, b);
        boundary();
        chk("R1/R2 inc sweep", inc_l, a);
        chk("R1/R2 dec sweep", dec_l, b);
      end
    end

    // R9: pulses without strobe leave latched values alone
    pulse(3, 0); boundary();
    pulse(9, 4);
    chk("R9 inc held", inc_l, 3);
    chk("R9 dec held", dec_l, 0);

    // R3: pulse coincides with strobe
    inc = 1; dec = 1; iend = 1; step(); inc = 0; dec = 0; iend = 0;
    chk("R2 inc at coincident strobe", inc_l, 9);
    chk("R2 dec at coincident strobe", dec_l, 4);
    pulse(4, 2); boundary();
    chk("R3 inc new interval", inc_l, 5);
    chk("R3 dec new interval", dec_l, 3);

    // R4/R5: boundary of range, both modes
    for (int m = 0; m < 2; m++) begin
      for (int n = MAXV - 2; n <= MAXV + 3; n++) begin
        int e;
        sat = m[0];
        pulse(n, MAXV);
        boundary();
        e = (m == 1) ? ((n > MAXV) ? MAXV : n) : (n % (MAXV + 1));
        chk(m ? "R5 inc saturate" : "R4 inc wrap", inc_l, e);
        chk(m ? "R5 dec at max" : "R4 dec at max", dec_l, MAXV);
      end
    end
    sat = 0;

    // R6: each alarm source clears latched and running counts
    for (int s = 0; s < 3; s++) begin
      pulse(5, 7); boundary();
      chk("R6 pre-alarm inc", inc_l, 5);
      pulse(6, 6);
      lop = (s == 0); ais = (s == 1); aais = (s == 2);
      iend = 1;  // strobe during alarm must not latch
      step();
      iend = 0;
      chk("R6 inc latched zero", inc_l, 0);
      chk("R6 dec latched zero", dec_l, 0);
      lop = 0; ais = 0; aais = 0;
      boundary();
      chk("R6 inc running cleared", inc_l, 0);
      chk("R6 dec running cleared", dec_l, 0);
    end

    // R7: pulses during LOP are discarded
    pulse(2, 2);
    lop = 1;
    pulse(10, 10);
    chk("R7 inc zero during lop", inc_l, 0);
    lop = 0;
    pulse(1, 0);
    boundary();
    chk("R7 inc after lop", inc_l, 1);
    chk("R7 dec after lop", dec_l, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule